// File: doc/BRIEF.md
# Two-Phase Dual-Rail AND Stage

This block is a clocked, synthesizable model of a word-wide AND stage. It works on a two-rail code that gives each logic value two code words, one for each of two phases. Successive data waves alternate phase, so no spacer wave is needed between them. Every bit of the word is stored in its own output register. That register takes a new value only when both of its operand digits have moved into the same phase, and that phase differs from the one the output digit already holds. While the operand digits are split between phases, the output digit keeps its value. So a bit that arrives late can never be combined with an operand from another wave.

A completion detector watches the output word. It raises a one-cycle flag once every output digit has entered the new phase, and it then flips a phase indicator that names the phase of the last completed wave. A monitor on the operand side flags a sequencing fault: a complete operand word whose content changed but which stays in the phase of the previous complete word. Each digit occupies two adjacent bits of a port, at [2i+1:2i]. The upper bit of the pair carries the value, and the XOR of the two bits gives the phase.

Top module: `fsl_and_stage`

## Requirements
- R1: A digit {hi,lo} has phase hi XOR lo and value hi. Its codes are 00 for phase 0 low, 11 for phase 0 high, 01 for phase 1 low and 10 for phase 1 high. Digit i of each port lies at bits [2i+1:2i].
- R2: Suppose operand digits a_i and b_i share a phase q and q differs from the phase of output digit i. Then on the next clock edge, output digit i becomes the code of phase q with value (value of a_i AND value of b_i).
- R3: In every other case output digit i holds its value. This covers operand digits in different phases, and operand digits in the same phase as the output digit.
- R4: Every change of an output digit toggles exactly one of its two rails.
- R5: While rst_n is low, every output digit is 00, wave_done and order_err are 0, and wave_phase is 0. The first wave expected after reset is therefore phase 1.
- R6: wave_done is 1 for exactly the cycle in which every output digit holds the phase opposite to wave_phase. That cycle is the one directly after the edge that moved the last digit.
- R7: wave_phase inverts on the edge that ends a wave_done cycle, and it is otherwise stable.
- R8: Suppose the whole operand word (all digits of both operands) is in one phase, that phase equals the phase of the previous complete operand word, and the content differs from that word. Then order_err is 1 in the following cycle. After reset, the previous complete word is all 00 in phase 0.
- R9: order_err stays 0 in two cases: for a complete operand word in the alternate phase, and for an operand word that is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_rails | input | 2*WIDTH | First operand, one two-rail digit per bit |
| b_rails | input | 2*WIDTH | Second operand, one two-rail digit per bit |
| y_rails | output | 2*WIDTH | Registered AND result, one two-rail digit per bit |
| wave_done | output | 1 | One-cycle flag: the whole output word has entered the new phase |
| wave_phase | output | 1 | Phase of the last completed output wave |
| order_err | output | 1 | Registered flag for a new complete operand word that repeats the previous phase |

## Verification
- **Output digit:** an output digit is due one edge after the operand change that completes it. The bench drives one operand digit per cycle on the falling edge, so arrivals are skewed in permuted orders. It then compares the whole output word at the next falling edge, which is after exactly one register.
- **wave_done:** this flag is combinational from registered state. It is therefore expected high at that same falling-edge sample after the last digit has been driven.
- **wave_phase:** the indicator is expected to have flipped one sample later.
- **order_err:** the fault flag passes through one register. It is expected one sample after the offending word is driven and back at 0 on the sample after that.

// File: rtl/fsl_pkg.sv
// Shared two-rail digit type and code helpers.
// A digit {hi,lo}: phase = hi ^ lo, value = hi.
package fsl_pkg;

    typedef logic [1:0] digit_t;

    // Phase carried by a digit.
    function automatic logic dig_phase(input digit_t d);
        return d[1] ^ d[0];
    endfunction

    // Logic value carried by a digit.
    function automatic logic dig_value(input digit_t d);
        return d[1];
    endfunction

    // Build the digit for a given phase and value.
    function automatic digit_t dig_code(input logic ph, input logic val);
        return {val, val ^ ph};
    endfunction

endpackage

// File: rtl/fsl_and_cell.sv
// One bit of the stage: a two-input AND on two-rail digits with hysteresis.
// The output register is loaded only when both operand digits agree on a
// phase that differs from the stored phase. Otherwise it holds.
// Assumes operands change by legal single-rail steps between phases.
module fsl_and_cell
    import fsl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  digit_t a_dig,
    input  digit_t b_dig,
    output digit_t y_dig
);

    logic   agree;
    logic   fresh;
    digit_t next_dig;

    // Decide whether the operands form a complete new wave for this bit.
    always_comb begin
        agree    = (dig_phase(a_dig) == dig_phase(b_dig));
        fresh    = agree && (dig_phase(a_dig) != dig_phase(y_dig));
        next_dig = dig_code(dig_phase(a_dig), dig_value(a_dig) & dig_value(b_dig));
    end

    // Output storage: load on a fresh wave, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            y_dig <= 2'b00;
        else if (fresh)
            y_dig <= next_dig;
    end

endmodule

// File: rtl/fsl_wave_done.sv
// Completion detector for the output word.
// Flags the cycle in which every output digit has left the phase of the
// last completed wave, then records the new phase.
module fsl_wave_done
    import fsl_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*WIDTH-1:0] y_word,
    output logic               done,
    output logic               phase_o
);

    logic [WIDTH-1:0] moved;
    logic             cur_phase;

    // Per-digit test: has this digit left the recorded phase?
    for (genvar i = 0; i < WIDTH; i++) begin : g_moved
        assign moved[i] = dig_phase(y_word[2*i +: 2]) ^ cur_phase;
    end

    // Whole word complete once every digit has moved.
    always_comb begin
        done = &moved;
    end

    // Record the phase of each completed wave.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_phase <= 1'b0;
        else if (done)
            cur_phase <= ~cur_phase;
    end

    assign phase_o = cur_phase;

endmodule

// File: rtl/fsl_order_watch.sv
// Operand-side sequencing monitor.
// Remembers the last operand word that was complete (all digits in one
// phase). It flags a newly complete word with different content that
// repeats the remembered phase. The flag is registered.
module fsl_order_watch
    import fsl_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*WIDTH-1:0] a_word,
    input  logic [2*WIDTH-1:0] b_word,
    output logic               order_err
);

    localparam int NDIG = 2 * WIDTH;
    localparam int WBITS = 2 * NDIG;

    logic [WBITS-1:0] word;
    logic [WBITS-1:0] last_word;
    logic             last_phase;
    logic [NDIG-1:0]  ph;
    logic             complete;
    logic             repeat_fault;

    assign word = {b_word, a_word};

    // Phase of every operand digit.
    for (genvar i = 0; i < NDIG; i++) begin : g_ph
        assign ph[i] = dig_phase(word[2*i +: 2]);
    end

    // Completeness and the repeated-phase fault condition.
    always_comb begin
        complete     = (&ph) | ~(|ph);
        repeat_fault = complete && (ph[0] == last_phase) && (word != last_word);
    end

    // Track the last complete word and register the fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_word  <= '0;
            last_phase <= 1'b0;
            order_err  <= 1'b0;
        end else begin
            order_err <= repeat_fault;
            if (complete) begin
                last_word  <= word;
                last_phase <= ph[0];
            end
        end
    end

endmodule

// File: rtl/fsl_and_stage.sv
// Word-wide two-phase dual-rail AND stage.
// One hysteresis cell per bit, a completion detector on the output word,
// and a sequencing monitor on the operands.
module fsl_and_stage
    import fsl_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*WIDTH-1:0] a_rails,
    input  logic [2*WIDTH-1:0] b_rails,
    output logic [2*WIDTH-1:0] y_rails,
    output logic               wave_done,
    output logic               wave_phase,
    output logic               order_err
);

    // Bit cells.
    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        fsl_and_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .a_dig (a_rails[2*i +: 2]),
            .b_dig (b_rails[2*i +: 2]),
            .y_dig (y_rails[2*i +: 2])
        );
    end

    fsl_wave_done #(.WIDTH(WIDTH)) u_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .y_word  (y_rails),
        .done    (wave_done),
        .phase_o (wave_phase)
    );

    fsl_order_watch #(.WIDTH(WIDTH)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_word    (a_rails),
        .b_word    (b_rails),
        .order_err (order_err)
    );

endmodule

// File: rtl/fsl_and_stage_chk.sv
// Property checker for fsl_and_stage, attached with bind below.
module fsl_and_stage_chk
    import fsl_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*WIDTH-1:0] a_rails,
    input logic [2*WIDTH-1:0] b_rails,
    input logic [2*WIDTH-1:0] y_rails,
    input logic               wave_done,
    input logic               wave_phase,
    input logic               order_err
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // R3
        split_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (dig_phase(a_rails[2*i +: 2]) != dig_phase(b_rails[2*i +: 2]))
            |=> $stable(y_rails[2*i +: 2]));

        // R4
        one_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(y_rails[2*i +: 2] ^ $past(y_rails[2*i +: 2])) <= 1);
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wave_done |=> !wave_done);

    // R7
    phase_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wave_done |=> (wave_phase != $past(wave_phase)));

    // R7
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wave_done |=> $stable(wave_phase));

    // R9
    quiet_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(a_rails) && $stable(b_rails)) |=> !order_err);

endmodule

bind fsl_and_stage fsl_and_stage_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_rails    (a_rails),
    .b_rails    (b_rails),
    .y_rails    (y_rails),
    .wave_done  (wave_done),
    .wave_phase (wave_phase),
    .order_err  (order_err)
);

// File: tb/sim_fsl_and_stage.sv
// Bench: exhaustive operand sweep with skewed digit arrival, plus fault cases.
module sim_fsl_and_stage;

    localparam int W = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2*W-1:0] a_r = '0;
    logic [2*W-1:0] b_r = '0;
    logic [2*W-1:0] y_r;
    logic           done_o;
    logic           phase_o;
    logic           err_o;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [2*W-1:0] exp_y = '0;
    logic [2*W-1:0] prev_y = '0;
    logic           model_phase = 1'b0;

    always #5 clk = ~clk;

    fsl_and_stage #(.WIDTH(W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_rails    (a_r),
        .b_rails    (b_r),
        .y_rails    (y_r),
        .wave_done  (done_o),
        .wave_phase (phase_o),
        .order_err  (err_o)
    );

    // R1 code helpers, written from the requirement.
    function automatic logic ph_of(input logic [1:0] d);
        return d[1] ^ d[0];
    endfunction

    function automatic logic [1:0] code_of(input logic p, input logic v);
        return {v, v ^ p};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R2/R3 expectation for output digits after the current operands.
    task automatic model_update();
        for (int i = 0; i < W; i++) begin
            logic [1:0] da;
            logic [1:0] db;
            da = a_r[2*i +: 2];
            db = b_r[2*i +: 2];
            if (ph_of(da) == ph_of(db) && ph_of(da) != ph_of(exp_y[2*i +: 2]))
                exp_y[2*i +: 2] = code_of(ph_of(da), da[1] & db[1]);
        end
    endtask

    function automatic logic model_done();
        logic all_moved;
        all_moved = 1'b1;
        for (int i = 0; i < W; i++)
            if (ph_of(exp_y[2*i +: 2]) == model_phase) all_moved = 1'b0;
        return all_moved;
    endfunction

    // Advance one clock and check outputs at the falling edge.
    task automatic step_check(input logic exp_err);
        model_update();
        @(negedge clk);
        check("R2/R3 output word", 32'(y_r), 32'(exp_y));
        check("R6 wave_done", 32'(done_o), 32'(model_done()));
        check("R8/R9 order_err", 32'(err_o), 32'(exp_err));
        for (int i = 0; i < W; i++)
            check("R4 rails toggled <= 1",
                  32'($countones(y_r[2*i +: 2] ^ prev_y[2*i +: 2]) <= 1), 32'd1);
        prev_y = y_r;
    endtask

    // Main stimulus.
    initial begin
        logic p;
        repeat (3) @(negedge clk);
        check("R5 reset y", 32'(y_r), 32'd0);
        check("R5 reset done", 32'(done_o), 32'd0);
        check("R5 reset phase", 32'(phase_o), 32'd0);
        check("R5 reset err", 32'(err_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 idle after reset", 32'({y_r, done_o, phase_o, err_o}), 32'd0);

        p = 1'b1;
        for (int op = 0; op < 256; op++) begin
            int k;
            int off;
            k = 2 * (op % 4) + 1;
            off = op % 8;
            for (int s = 0; s < 2 * W; s++) begin
                int idx;
                idx = (s * k + off) % (2 * W);
                if (idx < W)
                    a_r[2*idx +: 2] = code_of(p, op[idx]);
                else
                    b_r[2*(idx-W) +: 2] = code_of(p, op[W + idx - W]);
                step_check(1'b0);
            end
            model_phase = p;
            @(negedge clk);
            check("R7 phase after wave", 32'(phase_o), 32'(p));
            check("R6 done single cycle", 32'(done_o), 32'd0);
            p = ~p;
        end

        // R8: a changed word that repeats the last complete phase.
        a_r[1:0] = code_of(~p, ~a_r[1]);
        step_check(1'b1);
        @(negedge clk);
        check("R9 err clears", 32'(err_o), 32'd0);
        check("R3 held on repeat phase", 32'(y_r), 32'(exp_y));
        prev_y = y_r;

        // R9: legal wave in the alternate phase, all digits at once.
        for (int i = 0; i < W; i++) begin
            a_r[2*i +: 2] = code_of(p, 1'b1);
            b_r[2*i +: 2] = code_of(p, i[0]);
        end
        step_check(1'b0);
        model_phase = p;
        @(negedge clk);
        check("R7 phase after burst wave", 32'(phase_o), 32'(p));
        check("R9 no err on burst wave", 32'(err_o), 32'd0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule